// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of five numbered localities owns a shared security-module register interface. Each locality reaches its own one-byte access register through a separate 4 KB window, and the locality number is taken from address bits [14:12]. Software in a locality can ask for ownership, give it up, or take it from a lower-numbered owner by force. The block keeps the request, seize and been-seized flags for every locality and builds the byte that each locality reads back.

Every change of owner raises a one-cycle locality-change interrupt request. A handover that needs a new owner while a command is executing is not applied at once. The block raises an abort request and moves ownership only when the command engine reports that the command has finished or been aborted. Writes take effect at the clock edge that samples them. Reads are combinational from the registered state.

Top module: `locality_arbiter`

## Requirements
- R1: After reset no locality is active (active_loc_o = 0xFF), abort_req_o and loc_chg_irq_o are 0, and every access register reads 0x80 with bit 0 equal to the inverse of established_i.
- R2: A write with bit 1 (request) set, made while no locality is active, makes the writer active at the next edge.
- R3: A request write made while another locality is active sets the writer's request flag (read bit 1). Bit 2 (pending) of any locality's read byte is 1 exactly when some other locality has its request flag set.
- R4: When the owner writes bit 5 (active), ownership passes to the highest-numbered locality whose request flag is set. The old owner loses both active and request. The new owner reads bit 5 set and bit 1 clear.
- R5: A release by the owner while no locality is requesting leaves no locality active and raises no interrupt.
- R6: A write of bit 5 from a locality that does not own the interface clears only that locality's request flag and does not change the owner.
- R7: A write with bit 3 (seize) set is accepted only if no locality is active or if the writer's number is above the owner's number. Bits 1 and 5 of the same write are ignored, and bit 3 always reads back as 0.
- R8: After an accepted seize, the old owner reads bit 4 (been-seized) set. Writing 1 to bit 4 clears it.
- R9: Writes addressed to locality 4, and writes to any offset other than 0 within a window, change no state. Reads of any other offset or of a locality above 4 return 0xFF.
- R10: If cmd_busy_i is high when a handover is required, abort_req_o rises and the owner stays unchanged until cmd_done_i. At that edge the handover completes and abort_req_o falls.
- R11: A seize is refused when the writer already has a seize pending, or when a higher-numbered locality has one.
- R12: loc_chg_irq_o is high for exactly one cycle, in the cycle after active_loc_o takes a new locality value, and never when the interface becomes unowned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 15 | Write address; [14:12] give the locality, [11:0] the offset |
| wr_data_i | input | 8 | Write byte |
| rd_addr_i | input | 15 | Read address, decoded the same way |
| rd_data_o | output | 8 | Combinational read-back byte |
| established_i | input | 1 | Establishment state; reads back inverted in bit 0 |
| cmd_busy_i | input | 1 | A command is executing |
| cmd_done_i | input | 1 | The executing command finished or was aborted |
| abort_req_o | output | 1 | Handover is waiting; the command should be cancelled |
| active_loc_o | output | 8 | Owning locality, 0xFF when none |
| loc_chg_irq_o | output | 1 | One-cycle locality-change interrupt request |

## Verification
The hardest case to reach is a deferred handover that overlaps with further seize attempts. During this case the pending seize flag is invisible at the ports, and the refusal of a later seize can only be seen from which locality finally becomes the owner. The bench holds cmd_busy_i high, sends a seize from locality 3 and then a seize from locality 2, and checks that the owner does not change. It then pulses cmd_done_i and checks that locality 3, not locality 2, becomes the owner and that the old owner shows been-seized. Sweeps over every owner and seizer pair, and over every set of requesters at release, cover the priority rules.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam logic [7:0] NO_LOC = 8'hFF;
  // access byte bit positions
  localparam int unsigned B_VALID  = 7;
  localparam int unsigned B_ACTIVE = 5;
  localparam int unsigned B_SEIZED = 4;
  localparam int unsigned B_SEIZE  = 3;
  localparam int unsigned B_PEND   = 2;
  localparam int unsigned B_REQ    = 1;
  localparam int unsigned B_EST    = 0;
endpackage

// File: rtl/loc_prio_pick.sv
module loc_prio_pick #(
  parameter int unsigned NUM_LOC = 5,
  localparam int unsigned IDX_W  = $clog2(NUM_LOC)
) (
  input  logic [NUM_LOC-1:0] vec_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/loc_access_view.sv
module loc_access_view
  import loc_arb_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3,
  localparam int unsigned IDX_W  = $clog2(NUM_LOC)
) (
  input  logic [LOC_W-1:0]   rd_loc_i,
  input  logic               rd_off_hit_i,
  input  logic [7:0]         active_i,
  input  logic [NUM_LOC-1:0] req_i,
  input  logic [NUM_LOC-1:0] seized_i,
  input  logic               established_i,
  output logic [7:0]         data_o
);
  logic [IDX_W-1:0] idx;
  logic             loc_ok;
  logic             others_req;

  assign idx    = rd_loc_i[IDX_W-1:0];
  assign loc_ok = rd_loc_i < LOC_W'(NUM_LOC);

  always_comb begin
    others_req = 1'b0;
    for (int i = 0; i < NUM_LOC; i++)
      if (LOC_W'(i) != rd_loc_i) others_req |= req_i[i];
  end

  always_comb begin
    data_o = 8'hFF;
    if (rd_off_hit_i && loc_ok) begin
      data_o           = '0;
      data_o[B_VALID]  = 1'b1;
      data_o[B_ACTIVE] = active_i == {{(8-LOC_W){1'b0}}, rd_loc_i};
      data_o[B_SEIZED] = seized_i[idx];
      data_o[B_PEND]   = others_req;
      data_o[B_REQ]    = req_i[idx];
      data_o[B_EST]    = ~established_i;
    end
  end
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
  import loc_arb_pkg::*;
#(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned ADDR_W  = 15,
  parameter int unsigned LOC_LSB = 12,
  parameter int unsigned ACC_OFS = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic              established_i,
  input  logic              cmd_busy_i,
  input  logic              cmd_done_i,
  output logic              abort_req_o,
  output logic [7:0]        active_loc_o,
  output logic              loc_chg_irq_o
);
  localparam int unsigned LOC_W = ADDR_W - LOC_LSB;
  localparam int unsigned IDX_W = $clog2(NUM_LOC);
  localparam int unsigned SW    = 8 + 3*NUM_LOC;
  localparam logic [7:0]  NUM_B = 8'(NUM_LOC);

  logic [7:0]         act_q, tgt_q;
  logic [NUM_LOC-1:0] req_q, sz_q, bs_q;
  logic               pend_q, irq_q;

  // ownership switch: returns {active, req, seize, been_seized}
  function automatic logic [SW-1:0] switch_to(
      input logic [7:0] cur, input logic [NUM_LOC-1:0] r, input logic [NUM_LOC-1:0] s,
      input logic [NUM_LOC-1:0] b, input logic [7:0] nxt);
    if (cur != nxt && cur < NUM_B) begin
      if (nxt < NUM_B && s[nxt[IDX_W-1:0]]) b[cur[IDX_W-1:0]] = 1'b1;
      else                                  r[cur[IDX_W-1:0]] = 1'b0;
    end
    if (nxt < NUM_B) begin
      r[nxt[IDX_W-1:0]] = 1'b0;
      s[nxt[IDX_W-1:0]] = 1'b0;
    end
    return {nxt, r, s, b};
  endfunction

  function automatic logic changes(input logic [7:0] cur, input logic [7:0] nxt);
    return (cur != nxt) && (nxt < NUM_B);
  endfunction

  // stage 1: completion of a deferred handover
  logic [7:0]         a1;
  logic [NUM_LOC-1:0] r1, s1, b1;
  logic               irq1, pend1;

  always_comb begin
    {a1, r1, s1, b1} = {act_q, req_q, sz_q, bs_q};
    irq1  = 1'b0;
    pend1 = pend_q;
    if (pend_q && cmd_done_i) begin
      irq1  = changes(act_q, tgt_q);
      {a1, r1, s1, b1} = switch_to(act_q, req_q, sz_q, bs_q, tgt_q);
      pend1 = 1'b0;
    end
  end

  // write decode
  logic [LOC_W-1:0]   wr_loc;
  logic [IDX_W-1:0]   wr_idx;
  logic [7:0]         wl8;
  logic               wr_hit, hi_sz, pick_found;
  logic [IDX_W-1:0]   pick_idx;
  logic               unused_bits;

  assign wr_loc = wr_addr_i[LOC_LSB +: LOC_W];
  assign wr_idx = wr_loc[IDX_W-1:0];
  assign wl8    = {{(8-LOC_W){1'b0}}, wr_loc};
  assign wr_hit = wr_en_i && (wr_addr_i[LOC_LSB-1:0] == LOC_LSB'(ACC_OFS))
                  && (wr_loc < LOC_W'(NUM_LOC-1));
  assign unused_bits = ^{wr_data_i[B_VALID], wr_data_i[6], wr_data_i[B_PEND], wr_data_i[B_EST]};

  loc_prio_pick #(.NUM_LOC(NUM_LOC)) pick_i (
    .vec_i(r1), .found_o(pick_found), .idx_o(pick_idx));

  always_comb begin
    hi_sz = 1'b0;
    for (int i = 0; i < NUM_LOC; i++)
      if (LOC_W'(i) > wr_loc) hi_sz |= s1[i];
  end

  // stage 2: register write
  logic [7:0]         a2, tgt2, htgt, new_a;
  logic [NUM_LOC-1:0] r2, s2, b2;
  logic               irq2, pend2, hand, w_sz, w_act, w_req;

  always_comb begin
    {a2, r2, s2, b2} = {a1, r1, s1, b1};
    irq2  = irq1;
    pend2 = pend1;
    tgt2  = tgt_q;
    hand  = 1'b0;
    htgt  = NO_LOC;
    new_a = a1;
    w_sz  = wr_data_i[B_SEIZE];
    w_act = wr_data_i[B_ACTIVE] && !w_sz;
    w_req = wr_data_i[B_REQ] && !w_sz;
    if (wr_hit) begin
      if (w_act) begin
        if (a1 == wl8) begin
          if (pick_found) begin
            hand = 1'b1;
            htgt = {{(8-IDX_W){1'b0}}, pick_idx};
          end else begin
            new_a = NO_LOC;
          end
        end else begin
          r2[wr_idx] = 1'b0;
        end
      end
      if (wr_data_i[B_SEIZED]) b2[wr_idx] = 1'b0;
      if (w_sz && (a1 == NO_LOC || wl8 > a1) && !s1[wr_idx] && !hi_sz) begin
        for (int i = 0; i < NUM_LOC; i++)
          if (LOC_W'(i) < wr_loc) s2[i] = 1'b0;
        s2[wr_idx] = 1'b1;
        hand = 1'b1;
        htgt = wl8;
      end
      if (w_req && a1 != wl8) begin
        if (a1 != NO_LOC) r2[wr_idx] = 1'b1;
        else              new_a      = wl8;
      end
      if (hand && cmd_busy_i) begin
        pend2 = 1'b1;
        tgt2  = htgt;
      end else begin
        if (!hand) htgt = new_a;
        irq2 = irq2 | changes(a1, htgt);
        {a2, r2, s2, b2} = switch_to(a1, r2, s2, b2, htgt);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= NO_LOC;
      tgt_q  <= NO_LOC;
      req_q  <= '0;
      sz_q   <= '0;
      bs_q   <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      act_q  <= a2;
      tgt_q  <= tgt2;
      req_q  <= r2;
      sz_q   <= s2;
      bs_q   <= b2;
      pend_q <= pend2;
      irq_q  <= irq2;
    end
  end

  loc_access_view #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) view_i (
    .rd_loc_i     (rd_addr_i[LOC_LSB +: LOC_W]),
    .rd_off_hit_i (rd_addr_i[LOC_LSB-1:0] == LOC_LSB'(ACC_OFS)),
    .active_i     (act_q),
    .req_i        (req_q),
    .seized_i     (bs_q),
    .established_i(established_i),
    .data_o       (rd_data_o)
  );

  assign abort_req_o   = pend_q;
  assign active_loc_o  = act_q;
  assign loc_chg_irq_o = irq_q;
endmodule

// File: rtl/loc_arb_checker.sv
module loc_arb_checker #(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [LOC_W-1:0] wr_loc_i,
  input logic             cmd_done_i,
  input logic             abort_req_o,
  input logic [7:0]       active_loc_o,
  input logic             loc_chg_irq_o
);
  localparam logic [7:0] NUM_B = 8'(NUM_LOC);

  assert_active_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_loc_o < NUM_B) || (active_loc_o == 8'hFF));

  assert_defer_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_req_o && !cmd_done_i) |=> abort_req_o);

  assert_irq_on_change_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_chg_irq_o |-> (active_loc_o != $past(active_loc_o)) && (active_loc_o != 8'hFF));

  assert_change_raises_irq_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((active_loc_o != $past(active_loc_o)) && (active_loc_o != 8'hFF)) |-> loc_chg_irq_o);

  assert_top_loc_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_loc_i == LOC_W'(NUM_LOC-1) && !abort_req_o) |=> $stable(active_loc_o));
endmodule

bind locality_arbiter loc_arb_checker #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_loc_i     (wr_loc),
  .cmd_done_i   (cmd_done_i),
  .abort_req_o  (abort_req_o),
  .active_loc_o (active_loc_o),
  .loc_chg_irq_o(loc_chg_irq_o)
);

// File: tb/locality_arbiter_tb_top.sv
module locality_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [14:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        est = 1'b0;
  logic        busy = 1'b0;
  logic        done = 1'b0;
  logic        abort_req;
  logic [7:0]  active;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  locality_arbiter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .established_i(est), .cmd_busy_i(busy), .cmd_done_i(done),
    .abort_req_o(abort_req), .active_loc_o(active), .loc_chg_irq_o(irq));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    busy = 1'b0;
    done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int loc, input int off, input int d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 15'((loc << 12) | off);
    wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int loc, input int off, input int exp, input string tag);
    rd_addr = 15'((loc << 12) | off);
    #1;
    chk(tag, int'(rd_data), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk("R1 active", int'(active), 'hFF);
    chk("R1 abort", int'(abort_req), 0);
    chk("R1 irq", int'(irq), 0);
    for (int l = 0; l < 5; l++) rd(l, 0, 'h81, "R1 access");
    est = 1'b1;
    rd(0, 0, 'h80, "R1 est bit");
    est = 1'b0;
    rd(1, 'h18, 'hFF, "R9 other offset");
    rd(5, 0, 'hFF, "R9 bad locality");

    // R2
    wr(1, 0, 'h02);
    chk("R2 active", int'(active), 1);
    chk("R12 irq pulse", int'(irq), 1);
    rd(1, 0, 'hA1, "R2 owner byte");
    @(negedge clk);
    chk("R12 irq one cycle", int'(irq), 0);

    // R3
    wr(3, 0, 'h02);
    chk("R3 owner kept", int'(active), 1);
    rd(3, 0, 'h83, "R3 requester");
    rd(1, 0, 'hA5, "R3 pending at owner");
    wr(2, 0, 'h02);
    rd(3, 0, 'h87, "R3 pending at loc3");
    rd(2, 0, 'h87, "R3 pending at loc2");

    // R6
    wr(2, 0, 'h20);
    chk("R6 owner kept", int'(active), 1);
    rd(2, 0, 'h85, "R6 loc2 request cleared");
    rd(3, 0, 'h83, "R6 loc3 untouched");

    // R4
    wr(1, 0, 'h20);
    chk("R4 new owner", int'(active), 3);
    chk("R12 irq on release", int'(irq), 1);
    rd(1, 0, 'h81, "R4 old owner");
    rd(3, 0, 'hA1, "R4 new owner byte");

    // R5
    wr(3, 0, 'h20);
    chk("R5 none active", int'(active), 'hFF);
    chk("R5 no irq", int'(irq), 0);

    // R7 / R8
    wr(0, 0, 'h02);
    wr(2, 0, 'h2A);
    chk("R7 seize accepted", int'(active), 2);
    rd(0, 0, 'h91, "R8 been seized");
    rd(2, 0, 'hA1, "R7 seize/req bits ignored");
    wr(1, 0, 'h08);
    chk("R7 lower seize refused", int'(active), 2);
    wr(0, 0, 'h10);
    rd(0, 0, 'h81, "R8 been seized cleared");

    // R9
    wr(4, 0, 'h08);
    chk("R9 loc4 seize ignored", int'(active), 2);
    wr(3, 4, 'h02);
    rd(3, 0, 'h81, "R9 off offset ignored");

    // R10 / R11
    do_reset();
    wr(0, 0, 'h02);
    busy = 1'b1;
    wr(3, 0, 'h08);
    chk("R10 deferred owner", int'(active), 0);
    chk("R10 abort raised", int'(abort_req), 1);
    wr(2, 0, 'h08);
    repeat (3) @(negedge clk);
    chk("R10 still waiting", int'(active), 0);
    busy = 1'b0;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R11 higher seize wins", int'(active), 3);
    chk("R10 abort dropped", int'(abort_req), 0);
    chk("R12 irq after done", int'(irq), 1);
    rd(0, 0, 'h91, "R8 seized after defer");
    // deferred release
    wr(1, 0, 'h02);
    busy = 1'b1;
    wr(3, 0, 'h20);
    chk("R10 release deferred", int'(active), 3);
    busy = 1'b0;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk("R10 release completed", int'(active), 1);

    // R7 sweep: every owner / seizer pair
    for (int o = 0; o < 4; o++) begin
      for (int w = 0; w < 4; w++) begin
        do_reset();
        wr(o, 0, 'h02);
        wr(w, 0, 'h08);
        chk("R7 sweep owner", int'(active), (w > o) ? w : o);
        if (w > o) rd(o, 0, 'h91, "R8 sweep seized");
      end
    end

    // R4 sweep: every requester set at release
    for (int m = 0; m < 8; m++) begin
      int exp_loc;
      do_reset();
      wr(0, 0, 'h02);
      exp_loc = 'hFF;
      for (int k = 1; k < 4; k++) begin
        if (m[k-1]) begin
          wr(k, 0, 'h02);
          exp_loc = k;
        end
      end
      rd(0, 0, (m != 0) ? 'hA5 : 'hA1, "R3 sweep pending");
      wr(0, 0, 'h20);
      chk("R4 sweep next owner", int'(active), exp_loc);
      chk("R12 sweep irq", int'(irq), (m != 0) ? 1 : 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule